// File: doc/BRIEF.md
# DMA Channel Address Engine

This block sequences the transfers of one DMA channel. Software loads a source base address, a destination base address, a block length and a control byte. Each completed bus beat is reported on a strobe. The engine keeps a running byte count. It derives both transfer addresses from that count: the count is added to the base, subtracted from it, or ignored, depending on the mode of each address.

When the count reaches the block length, the engine signals completion. It raises a sticky flag and, if interrupts are enabled, an interrupt pulse. It then either rewinds to the base addresses for another pass, or turns the channel off. Bus timing and the choice among requesters belong to the surrounding logic. This block only supplies the addresses, the transfer size, the selected request source and the completion events.

Top module: `dmaeng_chan`

## Requirements
- R1: After a synchronous reset the byte count is 0, the channel is inactive, the completion flag is low, all event pulses are low and all registers read as 0.
- R2: Each address is the base plus the count when incrementing, the base minus the count when decrementing, and the base unchanged when static, all modulo 2^16. The 4-bit mode code selects the source mode and the destination mode as follows: 1010 inc/inc, 1001 inc/dec, 1000 inc/static, 0110 dec/inc, 0101 dec/dec, 0100 dec/static, 0010 static/inc, 0001 static/dec, 0000 static/static. Every other code acts as static/static.
- R3: Register writes use `wr_sel`: 0 is the source base, 1 the destination base, 2 the block length (data bits 7:0), 3 the control byte (data bits 7:0), 4 the channel config and 5 the flag clear. In the control byte, bits 7:4 hold the mode code, bit 3 the word select and bits 2:0 the request source, which appears on `req_src`.
- R4: While the channel is active, each `beat_done` pulse advances the count by the step. While the channel is inactive, `beat_done` leaves the count unchanged.
- R5: The word select takes effect only when at least one address is static. When it takes effect, `word_xfer` is high and the step is 2. Otherwise the step is 1.
- R6: A beat completes the block when count plus step reaches or exceeds the block length, where a length of 0 means 256. Completion resets the count to 0, sets `done_flag` and pulses `done_evt` for one cycle in the cycle after the beat.
- R7: `irq_evt` pulses together with `done_evt` exactly when config bit 1 (interrupt enable) is set.
- R8: On completion with config bit 2 (loop) set, the channel stays active and `restart_evt` pulses with `done_evt`. With loop clear, the channel becomes inactive.
- R9: A write to either base address clears the count. A beat in the same cycle as that write is dropped.
- R10: Config bit 0 written via select 4 sets or clears the channel's active state. A write to select 5 with data bit 0 set clears `done_flag`, unless a completion happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | 16 | Write data |
| beat_done | input | 1 | One transfer beat finished |
| src_addr | output | 16 | Current source address |
| dst_addr | output | 16 | Current destination address |
| word_xfer | output | 1 | Effective word-size transfer |
| req_src | output | 3 | Selected request source |
| byte_cnt | output | 8 | Running byte count |
| chan_active | output | 1 | Channel enabled for transfers |
| done_flag | output | 1 | Sticky completion flag |
| done_evt | output | 1 | Completion pulse |
| irq_evt | output | 1 | Interrupt request pulse |
| restart_evt | output | 1 | Loop restart pulse |

## Verification
The bench runs all sixteen mode codes, each with word select off and on. Bases are chosen so that decrementing the destination wraps below zero. This separates the legal codes from the illegal ones, increment from decrement, and an effective word request from an ignored one. A sweep over block lengths 1, 2, 3, 5, 255 and 0 finds the exact beat that completes the block, with the interrupt enable alternating between lengths. Separate sequences cover loop restarts, beats while inactive, an address write colliding with a beat, an odd length in word mode, and flag clearing.

// File: rtl/dmaeng_pkg.sv
package dmaeng_pkg;

    typedef enum logic [1:0] {
        AM_STATIC = 2'd0,
        AM_INC    = 2'd1,
        AM_DEC    = 2'd2
    } addr_mode_e;

    typedef struct packed {
        addr_mode_e src;
        addr_mode_e dst;
    } mode_pair_t;

    typedef struct packed {
        logic [3:0] mode;
        logic       word;
        logic [2:0] req;
    } chan_ctrl_t;

    typedef struct packed {
        logic loop_en;
        logic irq_en;
        logic enable;
    } chan_cfg_t;

    typedef enum logic [2:0] {
        SEL_SRC  = 3'd0,
        SEL_DST  = 3'd1,
        SEL_LEN  = 3'd2,
        SEL_CTRL = 3'd3,
        SEL_CFG  = 3'd4,
        SEL_FCLR = 3'd5
    } reg_sel_e;

    function automatic mode_pair_t decode_mode(input logic [3:0] code);
        mode_pair_t m;
        unique case (code)
            4'b1010: m = '{src: AM_INC,    dst: AM_INC};
            4'b1001: m = '{src: AM_INC,    dst: AM_DEC};
            4'b1000: m = '{src: AM_INC,    dst: AM_STATIC};
            4'b0110: m = '{src: AM_DEC,    dst: AM_INC};
            4'b0101: m = '{src: AM_DEC,    dst: AM_DEC};
            4'b0100: m = '{src: AM_DEC,    dst: AM_STATIC};
            4'b0010: m = '{src: AM_STATIC, dst: AM_INC};
            4'b0001: m = '{src: AM_STATIC, dst: AM_DEC};
            default: m = '{src: AM_STATIC, dst: AM_STATIC};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dmaeng_regs.sv
module dmaeng_regs
    import dmaeng_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] src_base,
    output logic [AW-1:0] dst_base,
    output logic [CW-1:0] blk_len,
    output chan_ctrl_t    ctrl,
    output logic          irq_en,
    output logic          loop_en,
    output logic          addr_wr,
    output logic          en_wr,
    output logic          en_val,
    output logic          flag_clr
);
    localparam int CTRL_W = $bits(chan_ctrl_t);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_base <= '0;
            dst_base <= '0;
            blk_len  <= '0;
            ctrl     <= '0;
            irq_en   <= 1'b0;
            loop_en  <= 1'b0;
        end else if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_SRC:  src_base <= wr_data;
                SEL_DST:  dst_base <= wr_data;
                SEL_LEN:  blk_len  <= wr_data[CW-1:0];
                SEL_CTRL: ctrl     <= chan_ctrl_t'(wr_data[CTRL_W-1:0]);
                SEL_CFG: begin
                    irq_en  <= wr_data[1];
                    loop_en <= wr_data[2];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        addr_wr  = wr_en && (wr_sel == SEL_SRC || wr_sel == SEL_DST);
        en_wr    = wr_en && (wr_sel == SEL_CFG);
        en_val   = wr_data[0];
        flag_clr = wr_en && (wr_sel == SEL_FCLR) && wr_data[0];
    end
endmodule

// File: rtl/dmaeng_addr.sv
module dmaeng_addr
    import dmaeng_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] cnt,
    input  addr_mode_e    mode,
    output logic [AW-1:0] addr
);
    localparam int PAD = AW - CW;
    logic [AW-1:0] offs;

    always_comb begin
        offs = {{PAD{1'b0}}, cnt};
        unique case (mode)
            AM_INC:  addr = base + offs;
            AM_DEC:  addr = base - offs;
            default: addr = base;
        endcase
    end
endmodule

// File: rtl/dmaeng_seq.sv
module dmaeng_seq #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          beat_done,
    input  logic          word_eff,
    input  logic [CW-1:0] blk_len,
    input  logic          irq_en,
    input  logic          loop_en,
    input  logic          addr_wr,
    input  logic          en_wr,
    input  logic          en_val,
    input  logic          flag_clr,
    output logic [CW-1:0] cnt,
    output logic          active,
    output logic          flag,
    output logic          done_p,
    output logic          irq_p,
    output logic          rs_p
);
    localparam int XW = CW + 1;
    localparam logic [XW-1:0] FULL = XW'(1) << CW;

    logic [XW-1:0] eff_len;
    logic [XW-1:0] nxt;
    logic          beat_ok;
    logic          fin;

    always_comb begin
        eff_len = (blk_len == '0) ? FULL : {1'b0, blk_len};
        nxt     = {1'b0, cnt} + (word_eff ? XW'(2) : XW'(1));
        beat_ok = beat_done && active && !addr_wr;
        fin     = beat_ok && (nxt >= eff_len);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= 1'b0;
            flag   <= 1'b0;
            done_p <= 1'b0;
            irq_p  <= 1'b0;
            rs_p   <= 1'b0;
        end else begin
            done_p <= fin;
            irq_p  <= fin && irq_en;
            rs_p   <= fin && loop_en;
            if (addr_wr || fin)
                cnt <= '0;
            else if (beat_ok)
                cnt <= nxt[CW-1:0];
            if (fin)
                flag <= 1'b1;
            else if (flag_clr)
                flag <= 1'b0;
            if (en_wr)
                active <= en_val;
            else if (fin && !loop_en)
                active <= 1'b0;
        end
    end
endmodule

// File: rtl/dmaeng_chan.sv
module dmaeng_chan
    import dmaeng_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic          beat_done,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic          word_xfer,
    output logic [2:0]    req_src,
    output logic [CW-1:0] byte_cnt,
    output logic          chan_active,
    output logic          done_flag,
    output logic          done_evt,
    output logic          irq_evt,
    output logic          restart_evt
);
    localparam int NPORT = 2;

    logic [AW-1:0] src_base, dst_base;
    logic [CW-1:0] blk_len;
    chan_ctrl_t    ctrl;
    logic          irq_en, loop_en, addr_wr, en_wr, en_val, flag_clr;
    mode_pair_t    modes;
    logic          word_eff;

    logic [AW-1:0] base_v [NPORT];
    addr_mode_e    mode_v [NPORT];
    logic [AW-1:0] addr_v [NPORT];

    dmaeng_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .src_base(src_base), .dst_base(dst_base), .blk_len(blk_len), .ctrl(ctrl),
        .irq_en(irq_en), .loop_en(loop_en), .addr_wr(addr_wr), .en_wr(en_wr),
        .en_val(en_val), .flag_clr(flag_clr)
    );

    always_comb begin
        modes     = decode_mode(ctrl.mode);
        word_eff  = ctrl.word && (modes.src == AM_STATIC || modes.dst == AM_STATIC);
        base_v[0] = src_base;
        base_v[1] = dst_base;
        mode_v[0] = modes.src;
        mode_v[1] = modes.dst;
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_addr
        dmaeng_addr #(.AW(AW), .CW(CW)) u_addr (
            .base(base_v[g]), .cnt(byte_cnt), .mode(mode_v[g]), .addr(addr_v[g])
        );
    end

    dmaeng_seq #(.CW(CW)) u_seq (
        .clk(clk), .rst(rst), .beat_done(beat_done), .word_eff(word_eff),
        .blk_len(blk_len), .irq_en(irq_en), .loop_en(loop_en), .addr_wr(addr_wr),
        .en_wr(en_wr), .en_val(en_val), .flag_clr(flag_clr),
        .cnt(byte_cnt), .active(chan_active), .flag(done_flag),
        .done_p(done_evt), .irq_p(irq_evt), .rs_p(restart_evt)
    );

    assign src_addr  = addr_v[0];
    assign dst_addr  = addr_v[1];
    assign word_xfer = word_eff;
    assign req_src   = ctrl.req;
endmodule

// File: rtl/dmaeng_chan_chk.sv
module dmaeng_chan_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          addr_wr,
    input logic          en_wr,
    input logic          chan_active,
    input logic [CW-1:0] byte_cnt,
    input logic          done_flag,
    input logic          done_evt,
    input logic          irq_evt,
    input logic          restart_evt
);
    // R9
    addr_write_clears_chk: assert property (@(posedge clk) disable iff (rst)
        addr_wr |=> (byte_cnt == '0));

    // R4
    idle_count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!chan_active && !addr_wr) |=> $stable(byte_cnt));

    // R6
    done_count_zero_chk: assert property (@(posedge clk) disable iff (rst)
        done_evt |-> (byte_cnt == '0 && done_flag));

    // R7
    irq_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        irq_evt |-> done_evt);

    // R8
    restart_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        restart_evt |-> done_evt);

    // R8
    stop_without_loop_chk: assert property (@(posedge clk) disable iff (rst)
        (done_evt && !restart_evt && !$past(en_wr)) |-> !chan_active);
endmodule

bind dmaeng_chan dmaeng_chan_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .addr_wr(addr_wr), .en_wr(en_wr),
    .chan_active(chan_active), .byte_cnt(byte_cnt), .done_flag(done_flag),
    .done_evt(done_evt), .irq_evt(irq_evt), .restart_evt(restart_evt)
);

// File: tb/dmaeng_chan_test.sv
module dmaeng_chan_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        beat_done = 1'b0;
    logic [15:0] src_addr, dst_addr;
    logic        word_xfer;
    logic [2:0]  req_src;
    logic [7:0]  byte_cnt;
    logic        chan_active, done_flag, done_evt, irq_evt, restart_evt;

    int errors = 0;
    int checks = 0;
    logic s_done, s_irq, s_rs;

    dmaeng_chan uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .beat_done(beat_done), .src_addr(src_addr), .dst_addr(dst_addr),
        .word_xfer(word_xfer), .req_src(req_src), .byte_cnt(byte_cnt),
        .chan_active(chan_active), .done_flag(done_flag), .done_evt(done_evt),
        .irq_evt(irq_evt), .restart_evt(restart_evt)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic beat();
        beat_done = 1'b1;
        @(negedge clk);
        beat_done = 1'b0;
        s_done = done_evt; s_irq = irq_evt; s_rs = restart_evt;
    endtask

    // modes: 0 static, 1 inc, 2 dec; returns {src,dst}
    function automatic logic [3:0] ref_modes(input logic [3:0] c);
        case (c)
            4'hA: return {2'd1, 2'd1};
            4'h9: return {2'd1, 2'd2};
            4'h8: return {2'd1, 2'd0};
            4'h6: return {2'd2, 2'd1};
            4'h5: return {2'd2, 2'd2};
            4'h4: return {2'd2, 2'd0};
            4'h2: return {2'd0, 2'd1};
            4'h1: return {2'd0, 2'd2};
            default: return 4'd0;
        endcase
    endfunction

    function automatic logic [15:0] ref_addr(input logic [15:0] b, input int n, input logic [1:0] m);
        if (m == 2'd1) return b + 16'(n);
        if (m == 2'd2) return b - 16'(n);
        return b;
    endfunction

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lens [6] = '{1, 2, 3, 5, 255, 0};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(byte_cnt == 0 && !chan_active && !done_flag, "R1", {byte_cnt, chan_active, done_flag}, 0);
        chk(!done_evt && !irq_evt && !restart_evt && src_addr == 0 && dst_addr == 0 && req_src == 0,
            "R1", {done_evt, irq_evt, restart_evt}, 0);

        // R2 R3 R5 mode sweep
        for (int code = 0; code < 16; code++) begin
            for (int w = 0; w < 2; w++) begin
                logic [3:0] mp;
                bit weff;
                int n;
                mp = ref_modes(4'(code));
                weff = (w == 1) && (mp[3:2] == 0 || mp[1:0] == 0);
                wr(3'd0, 16'h1234);
                wr(3'd1, 16'h0003);
                wr(3'd2, 16'h0000);
                wr(3'd3, {8'h00, 4'(code), 1'(w), 3'(code)});
                wr(3'd4, 16'h0001);
                repeat (3) beat();
                n = weff ? 6 : 3;
                chk(byte_cnt == 8'(n), "R5", byte_cnt, n);
                chk(word_xfer == weff, "R5", word_xfer, weff);
                chk(req_src == 3'(code), "R3", req_src, code[2:0]);
                chk(src_addr == ref_addr(16'h1234, n, mp[3:2]), "R2", src_addr, ref_addr(16'h1234, n, mp[3:2]));
                chk(dst_addr == ref_addr(16'h0003, n, mp[1:0]), "R2", dst_addr, ref_addr(16'h0003, n, mp[1:0]));
            end
        end

        // R6 R7 R8 length sweep without loop
        foreach (lens[i]) begin
            int L;
            bit ie;
            L = (lens[i] == 0) ? 256 : lens[i];
            ie = i[0];
            wr(3'd0, 16'h0100);
            wr(3'd1, 16'h0200);
            wr(3'd2, 16'(lens[i]));
            wr(3'd3, 16'h00A0);
            wr(3'd4, {13'd0, 1'b0, ie, 1'b1});
            wr(3'd5, 16'h0001);
            for (int b = 1; b < L; b++) begin
                beat();
                if (s_done || byte_cnt != 8'(b)) chk(0, "R6", byte_cnt, b);
            end
            chk(byte_cnt == 8'(L - 1) && chan_active, "R4", byte_cnt, L - 1);
            beat();
            chk(s_done == 1 && byte_cnt == 0 && done_flag, "R6", {s_done, byte_cnt, done_flag}, 12'h101);
            chk(s_irq == ie, "R7", s_irq, ie);
            chk(!chan_active && !s_rs, "R8", {chan_active, s_rs}, 0);
            @(negedge clk);
            chk(!done_evt && done_flag, "R6", {done_evt, done_flag}, 1);
            wr(3'd5, 16'h0001);
            chk(!done_flag, "R10", done_flag, 0);
        end

        // R8 loop mode, length 3, seven beats
        wr(3'd0, 16'h0010);
        wr(3'd2, 16'h0003);
        wr(3'd4, 16'h0007);
        for (int b = 1; b <= 7; b++) begin
            beat();
            chk(s_rs == (b % 3 == 0) && s_done == (b % 3 == 0), "R8", s_rs, (b % 3 == 0));
            chk(chan_active, "R8", chan_active, 1);
        end
        chk(byte_cnt == 1 && src_addr == 16'h0011, "R8", byte_cnt, 1);

        // R10 disable, then R4 beats ignored
        wr(3'd4, 16'h0000);
        chk(!chan_active && byte_cnt == 1, "R10", {chan_active, byte_cnt}, 1);
        beat();
        beat();
        chk(byte_cnt == 1 && !s_done, "R4", byte_cnt, 1);

        // R9 address write colliding with a beat
        wr(3'd4, 16'h0001);
        beat();
        chk(byte_cnt == 2, "R4", byte_cnt, 2);
        wr_en = 1'b1; wr_sel = 3'd1; wr_data = 16'h0300; beat_done = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; beat_done = 1'b0;
        chk(byte_cnt == 0 && dst_addr == 16'h0300, "R9", byte_cnt, 0);

        // R5 R6 word mode with odd length: static source, incrementing destination
        wr(3'd3, 16'h0028);
        wr(3'd2, 16'h0003);
        beat();
        chk(byte_cnt == 2 && !s_done && dst_addr == 16'h0302, "R5", byte_cnt, 2);
        beat();
        chk(s_done && byte_cnt == 0 && !chan_active, "R6", {s_done, byte_cnt}, 12'h100);

        // R10 completion beats a simultaneous flag clear
        wr(3'd5, 16'h0001);
        wr(3'd2, 16'h0001);
        wr(3'd4, 16'h0001);
        wr_en = 1'b1; wr_sel = 3'd5; wr_data = 16'h0001; beat_done = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; beat_done = 1'b0;
        chk(done_flag, "R10", done_flag, 1);

        // R1 reset clears state again
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(byte_cnt == 0 && !chan_active && !done_flag && req_src == 0, "R1", {chan_active, done_flag}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule